// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block is an N×N grid of multiply-accumulate cells that multiplies a stream of activation vectors by a fixed weight matrix. The weights are loaded first and stay in the cells. Each cell (k,j) holds one signed 8-bit weight W[k][j].

After the load, one signed 8-bit activation vector can enter per clock. Element k goes into row k on the left edge. It moves one cell to the right on every clock and is passed on unchanged, so it is read from the input once and reaches every cell of its row over wires. Partial sums move down the columns. Each column leaves the bottom edge with a 32-bit dot product.

Input skew registers hold each row back so that it meets the right partial sum. Output de-skew registers line the columns up, so that all N results of one vector appear in the same cycle together with a valid flag. Nothing in the grid stalls or schedules work, so the latency depends only on N. An operand narrower than the array must be zero-padded by the user, and the padded cells still take part in every cycle. N must be at least 2.

Top module: `sa_matmul`

## Requirements
- R1: The design treats each input vector `in_act` as N signed 8-bit elements, with element k at bits [8k+7:8k]. For each vector the block returns N signed 32-bit results. Result j is at `out_res` bits [32j+31:32j] and equals the sum over k of act[k]·W[k][j], computed exactly in two's complement.
- R2: An accepted weight load captures `w_row` into grid row 0, with element j at bits [8j+7:8j] going to column j. In the same clock every other row k takes the previous contents of row k−1. After N accepted loads, the row loaded first sits in row N−1 and the row loaded last sits in row 0.
- R3: Weights stay unchanged for any number of idle cycles and any number of computed vectors, until the next accepted load.
- R4: A vector sampled at a rising edge with `in_valid` high has its results and `out_valid` high during the cycle that follows the (2N−1)-th rising edge, counting the sampling edge as the first.
- R5: Vectors may enter on consecutive cycles with no stall. Each accepted vector produces exactly one output vector, in input order, one per cycle, and adjacent vectors do not disturb each other.
- R6: `out_valid` is high only in cycles that carry the result of an accepted vector. Gaps in `in_valid` appear as gaps of the same length at the output.
- R7: A weight load is refused, leaving every weight unchanged, in two cases: when `in_valid` is high in the same cycle, and while any accepted vector has not yet produced its output.
- R8: After synchronous active-high reset, `out_valid` is low, `out_res` is zero and all weights are zero. A vector computed before any new load therefore gives all-zero results.
- R9: Extreme operands (−128, +127 in any mix, on every element) give exact results with no overflow or wrap.
- R10: `in_act` is ignored in cycles where `in_valid` is low, and such cycles do not change the result of any accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| w_load | input | 1 | Request to shift `w_row` into the weight grid |
| w_row | input | N*8 | One row of signed weights, column j at [8j+7:8j] |
| in_valid | input | 1 | `in_act` holds a vector to compute this cycle |
| in_act | input | N*8 | Activation vector, element k at [8k+7:8k] |
| out_valid | output | 1 | `out_res` holds a finished result vector |
| out_res | output | N*32 | Signed dot products, column j at [32j+31:32j] |

## Verification
The hardest case to reach from the ports is a weight load that arrives while vectors are still in the grid. This includes a load in the same cycle as `in_valid` and loads held during a drain. A refused load shows nothing at once; it can only be seen later, in the results of a following batch. The stimulus therefore starts a vector and holds `w_load` high with a distinctive row during that vector's flight. It also raises the load together with `in_valid`, and waits until the grid has drained. It then streams a new batch whose expected values use the old weight matrix. Any weight that moved would show up there as a wrong dot product. Gaps are also driven with non-zero junk on `in_act`. This confirms that skipped cycles neither leak into the sums nor produce extra valid pulses.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // operand and accumulator widths shared by every piece of the grid
    localparam int unsigned OPW  = 8;
    localparam int unsigned ACCW = 32;
    localparam int unsigned PRODW = 2 * OPW;

    typedef logic signed [OPW-1:0]   operand_t;
    typedef logic signed [PRODW-1:0] prod_t;
    typedef logic signed [ACCW-1:0]  acc_t;

    // one step of a column: running sum plus signed product, sign extended
    function automatic acc_t mac_step(acc_t sum_in, operand_t act, operand_t wgt);
        prod_t p;
        p = act * wgt;
        return sum_in + acc_t'(p);
    endfunction

endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/sa_cell.sv
module sa_cell
    import sa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     w_en,
    input  operand_t w_in,
    output operand_t w_q,
    input  operand_t act_in,
    input  acc_t     psum_in,
    output operand_t act_out,
    output acc_t     psum_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q      <= '0;
            act_out  <= '0;
            psum_out <= '0;
        end else begin
            if (w_en) w_q <= w_in;
            act_out  <= act_in;
            psum_out <= mac_step(psum_in, act_in, w_q);
        end
    end

    // R1: a zero activation adds nothing to the sum passing down the column
    a_r1_zero_act_passes_sum: assert property (@(posedge clk) disable iff (rst)
        (act_in == '0) |=> (psum_out == $past(psum_in)));

endmodule

// File: rtl/sa_matmul.sv
module sa_matmul
    import sa_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            w_load,
    input  logic [N*OPW-1:0] w_row,
    input  logic            in_valid,
    input  logic [N*OPW-1:0] in_act,
    output logic            out_valid,
    output logic [N*ACCW-1:0] out_res
);

    localparam int unsigned LAT  = 2 * N - 1;
    localparam int unsigned CNTW = $clog2(LAT + 1) + 1;

    logic [LAT-1:0] vpipe;
    logic           busy;
    logic           w_shift;

    operand_t w_grid [N][N];
    operand_t a_grid [N][N+1];
    acc_t     p_grid [N+1][N];
    logic [N*N*OPW-1:0] w_all;
    logic     unused_tail;

    // a load is taken only when nothing is entering or travelling in the grid
    assign busy    = in_valid | (|vpipe);
    assign w_shift = w_load & ~busy;

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], in_valid};
    end
    assign out_valid = vpipe[LAT-1];

    genvar k, j;
    generate
        // left edge: gate idle cycles to zero, delay row k by k cycles
        for (k = 0; k < N; k++) begin : g_skew
            operand_t edge_act;
            assign edge_act = in_valid ? operand_t'(in_act[k*OPW +: OPW]) : '0;
            if (k == 0) begin : g_direct
                assign a_grid[k][0] = edge_act;
            end else begin : g_delayed
                sa_delay #(.WIDTH(OPW), .DEPTH(k)) u_skew (
                    .clk(clk), .rst(rst), .d(edge_act), .q(a_grid[k][0])
                );
            end
        end

        for (j = 0; j < N; j++) begin : g_top_zero
            assign p_grid[0][j] = '0;
        end

        for (k = 0; k < N; k++) begin : g_row
            for (j = 0; j < N; j++) begin : g_col
                operand_t w_src;
                if (k == 0) begin : g_w_port
                    assign w_src = operand_t'(w_row[j*OPW +: OPW]);
                end else begin : g_w_above
                    assign w_src = w_grid[k-1][j];
                end
                sa_cell u_cell (
                    .clk(clk), .rst(rst),
                    .w_en(w_shift), .w_in(w_src), .w_q(w_grid[k][j]),
                    .act_in(a_grid[k][j]), .psum_in(p_grid[k][j]),
                    .act_out(a_grid[k][j+1]), .psum_out(p_grid[k+1][j])
                );
                assign w_all[(k*N+j)*OPW +: OPW] = w_grid[k][j];
            end
        end

        // bottom edge: column j waits N-1-j cycles so all columns line up
        for (j = 0; j < N; j++) begin : g_deskew
            if (j == N - 1) begin : g_direct
                assign out_res[j*ACCW +: ACCW] = p_grid[N][j];
            end else begin : g_delayed
                sa_delay #(.WIDTH(ACCW), .DEPTH(N-1-j)) u_align (
                    .clk(clk), .rst(rst), .d(p_grid[N][j]),
                    .q(out_res[j*ACCW +: ACCW])
                );
            end
        end
    endgenerate

    // activations leaving the right edge go nowhere
    always_comb begin
        unused_tail = 1'b0;
        for (int r = 0; r < N; r++) unused_tail = unused_tail ^ (^a_grid[r][N]);
    end

    // checker state: vectors accepted but not yet delivered
    logic [CNTW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + CNTW'(in_valid) - CNTW'(out_valid);
    end

    // R6: every valid output belongs to an accepted vector
    a_r6_no_orphan_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    // R5: the grid never holds more vectors than its pipeline depth
    a_r5_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= CNTW'(LAT));

    // R7: weights do not move while a vector is entering or in flight
    a_r7_weights_frozen: assert property (@(posedge clk) disable iff (rst)
        (in_valid || (vpipe != '0)) |=> $stable(w_all));

    // R2: an idle-time load lands in row 0
    a_r2_row0_takes_input: assert property (@(posedge clk) disable iff (rst)
        (w_load && !in_valid && (vpipe == '0)) |=> (w_all[N*OPW-1:0] == $past(w_row)));

    // R8: reset leaves no valid result behind
    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/test_sa_matmul.sv
module test_sa_matmul;

    localparam int N   = 4;
    localparam int LAT = 2 * N - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              w_load   = 1'b0;
    logic [N*8-1:0]    w_row    = '0;
    logic              in_valid = 1'b0;
    logic [N*8-1:0]    in_act   = '0;
    logic              out_valid;
    logic [N*32-1:0]   out_res;

    sa_matmul #(.N(N)) i_sa_matmul (
        .clk(clk), .rst(rst),
        .w_load(w_load), .w_row(w_row),
        .in_valid(in_valid), .in_act(in_act),
        .out_valid(out_valid), .out_res(out_res)
    );

    // stimulus table: activation vectors, element k at [8k+7:8k]
    localparam logic [N*8-1:0] ACT_TAB [10] = '{
        32'h04030201, 32'h7F7F7F7F, 32'h80808080, 32'h807F0180, 32'hFF00FF00,
        32'h00000000, 32'h01FF7F80, 32'hFFFFFFFF, 32'h12345678, 32'h7F807F80
    };

    int errors = 0;
    int checks = 0;
    int cycle  = 0;
    string req = "R8";
    int ref_w [N][N];
    logic [N*32-1:0] exp_q [$];
    int t_q [$];
    logic [31:0] lf = 32'hACE12345;

    always @(posedge clk) cycle <= cycle + 1;

    task automatic check_vec(string tag, logic [N*32-1:0] got, logic [N*32-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_int(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [N*32-1:0] model(logic [N*8-1:0] a);
        logic [N*32-1:0] r;
        for (int j = 0; j < N; j++) begin
            int s = 0;
            for (int k = 0; k < N; k++) s += int'($signed(a[8*k +: 8])) * ref_w[k][j];
            r[32*j +: 32] = s;
        end
        return r;
    endfunction

    function automatic logic [7:0] wgen(int kind, int r, int j);
        case (kind)
            1:       return 8'h80;
            2:       return ((r + j) % 2 == 0) ? 8'h7F : 8'h80;
            default: return 8'((r * 37 + j * 91 + kind * 53) * 73 + 11);
        endcase
    endfunction

    // scoreboard: order, value (R1/R5/R9...) and latency (R4) of each output
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6: got=valid with no pending vector expected=idle");
            end else begin
                logic [N*32-1:0] e;
                int t;
                e = exp_q.pop_front();
                t = t_q.pop_front();
                check_vec(req, out_res, e);
                check_int("R4 latency", cycle - t, LAT);
            end
        end
    end

    task automatic send(logic [N*8-1:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_act   = a;
        exp_q.push_back(model(a));
        t_q.push_back(cycle);
    endtask

    // R10: idle cycles carry non-zero junk on in_act
    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_act   = 32'hA5C37E19;
        end
    endtask

    task automatic load_matrix(int kind);
        for (int r = N - 1; r >= 0; r--) begin
            @(negedge clk);
            w_load = 1'b1;
            for (int j = 0; j < N; j++) w_row[8*j +: 8] = wgen(kind, r, j);
            for (int q = N - 1; q > 0; q--)
                for (int j = 0; j < N; j++) ref_w[q][j] = ref_w[q-1][j];
            for (int j = 0; j < N; j++) ref_w[0][j] = int'($signed(w_row[8*j +: 8]));
        end
        @(negedge clk);
        w_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4: got=watchdog expiry expected=run complete");
        finish_run();
    end

    initial begin
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) ref_w[k][j] = 0;
        repeat (3) @(negedge clk);
        check_int("R8 out_valid after reset", int'(out_valid), 0);
        check_vec("R8 out_res after reset", out_res, '0);
        rst = 1'b0;

        // R8: weights reset to zero
        req = "R8 zero weights";
        send(ACT_TAB[1]);
        idle(LAT + 2);

        // main table walk over several weight matrices, back to back (R5)
        for (int kind = 0; kind < 3; kind++) begin
            load_matrix(kind);
            req = (kind == 0) ? "R1 R5 random weights" : "R9 extreme weights";
            for (int i = 0; i < 10; i++) send(ACT_TAB[i]);
            idle(LAT + 2);
        end

        // R10 / R6: gapped stream with junk in the gaps
        req = "R10 gapped stream";
        for (int i = 0; i < 8; i++) begin
            send(ACT_TAB[i]);
            idle(1 + i % 2);
        end
        idle(LAT + 2);

        // R7: load in the same cycle as in_valid, then loads during flight
        req = "R7 refused load";
        @(negedge clk);
        in_valid = 1'b1;
        in_act   = ACT_TAB[5 + 3];
        w_load   = 1'b1;
        w_row    = 32'h11111111;
        exp_q.push_back(model(in_act));
        t_q.push_back(cycle);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        w_load = 1'b0;
        idle(LAT + 2);
        for (int i = 0; i < 4; i++) send(ACT_TAB[i]);
        idle(LAT + 2);

        // R3: weights held across a long idle stretch
        idle(50);
        req = "R3 retention";
        send(ACT_TAB[6]);
        send(ACT_TAB[7]);
        idle(LAT + 2);

        // R5: long random batch
        load_matrix(3);
        req = "R5 random batch";
        for (int i = 0; i < 40; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            send(lf);
        end
        idle(LAT + 2);

        // R8: reset after a load clears the weights
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_int("R8 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) ref_w[k][j] = 0;
        req = "R8 cleared weights";
        send(ACT_TAB[9]);
        idle(LAT + 2);

        check_int("R5 outputs outstanding", exp_q.size(), 0);
        finish_run();
    end

endmodule